// File: doc/BRIEF.md
# USB Vendor Request to UART Register Bridge

This block sits behind a USB control-transfer parser and turns a small set of vendor requests into register traffic for a 16550-style serial port. The host writes a 32-bit baud divisor (115200 divided by the wanted baud rate), the line control byte and the modem control byte. It reads back the line control byte or the live modem status byte. Each request arrives as one setup strobe that carries the request type, the request code and the data length. Write data follows on a valid/ready byte stream. Read data leaves on a second valid/ready byte stream.

Alongside the request path, the block watches the live modem status and line status bytes from the UART. When a modem delta bit or a line error bit changes, it queues a two-byte status report for the interrupt pipe, modem status first and line status second. A request the block does not recognise produces a one-cycle stall pulse and changes no register.

Top module: `vreq_uart_bridge`

## Requirements
- R1: After reset the divisor output is 0, the line control output is 0x00, the modem control output is 0x08 (DTR and RTS both inactive), and stall, wr_ready, rd_valid and rpt_valid are all low.
- R2: A setup with type 0x40, code 5 and length 4 opens a write phase. In that phase the four data bytes are placed least significant byte first into the 32-bit divisor. The divisor output keeps its old value until the fourth byte is accepted and changes in the cycle after that handshake.
- R3: A setup with type 0x40, code 7 and length 1 loads the next accepted data byte into the line control output.
- R4: A setup with type 0x40, code 10 and length 1 loads the next accepted data byte into the modem control output unchanged. For example, 0x0A asserts RTS, 0x09 asserts DTR and 0x08 releases both.
- R5: A setup with type 0xC0, code 6 and length 1 returns the current line control value as one byte on the read stream.
- R6: A setup with type 0xC0, code 2 and length 1 returns the modem status byte sampled in the setup cycle, even if the live value changes before the byte is taken.
- R7: A setup with any other combination of type, code and length raises stall for exactly one cycle. It opens no data phase and leaves divisor, line control and modem control unchanged.
- R8: A change in modem status bits 3..0, or in line status bit 7 or bits 4..1, queues a report. The report is two bytes: the full modem status byte, then the full line status byte, with rpt_last high on the second byte.
- R9: Changes confined to modem status bits 7..4 or line status bits 6, 5 and 0 queue no report.
- R10: A watched change that arrives while a report is pending replaces the pending report with the newest values. The new report restarts from the modem status byte, and this change takes precedence over a byte handshake in the same cycle.
- R11: wr_ready is high only during a write data phase. rd_valid and rd_data hold steady until rd_ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | One-cycle strobe: setup fields are valid |
| setup_type | input | 8 | Request type byte |
| setup_code | input | 8 | Request code byte |
| setup_len | input | 16 | Data stage length in bytes |
| wr_valid | input | 1 | Write data byte valid |
| wr_data | input | 8 | Write data byte |
| wr_ready | output | 1 | Bridge accepts a write data byte |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| rd_ready | input | 1 | Host takes the read byte |
| msr_in | input | 8 | Live modem status byte from the UART |
| lsr_in | input | 8 | Live line status byte from the UART |
| stall | output | 1 | One-cycle pulse for a rejected request |
| divisor | output | 32 | Baud divisor register |
| lcr | output | 8 | Line control register |
| mcr | output | 8 | Modem control register |
| rpt_valid | output | 1 | Status report byte valid |
| rpt_data | output | 8 | Status report byte |
| rpt_last | output | 1 | Marks the second report byte |
| rpt_ready | input | 1 | Consumer takes the report byte |

## Verification
A new status change and the handshake of a report byte can land in the same cycle, and both update the report state. The bench creates this overlap by raising rpt_ready on the first byte of a pending report and changing a watched line status bit at the same falling edge. It then expects the modem byte to be offered again with rpt_last low, followed by the new line status byte. Request handling runs beside the reporter, so a modem status read is also issued while live modem bits move, to confirm that the byte returned is the one captured at setup.

// File: rtl/vreq_pkg.sv
package vreq_pkg;

    localparam logic [7:0] REQ_TYPE_WR  = 8'h40;
    localparam logic [7:0] REQ_TYPE_RD  = 8'hC0;
    localparam logic [7:0] CODE_DIV_WR  = 8'd5;
    localparam logic [7:0] CODE_LINE_WR = 8'd7;
    localparam logic [7:0] CODE_LINE_RD = 8'd6;
    localparam logic [7:0] CODE_MDM_WR  = 8'd10;
    localparam logic [7:0] CODE_STAT_RD = 8'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WDATA,
        ST_RDATA
    } phase_e;

    typedef enum logic [1:0] {
        TG_DIV,
        TG_LINE,
        TG_MDM
    } target_e;

endpackage

// File: rtl/vreq_ctrl.sv
module vreq_ctrl
    import vreq_pkg::*;
#(
    parameter int DIV_W    = 32,
    parameter int LEN_W    = 16,
    parameter logic [7:0] MCR_INIT = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic [7:0]       setup_type,
    input  logic [7:0]       setup_code,
    input  logic [LEN_W-1:0] setup_len,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    input  logic             rd_ready,
    input  logic [7:0]       msr_in,
    output logic             stall,
    output logic [DIV_W-1:0] divisor,
    output logic [7:0]       lcr,
    output logic [7:0]       mcr
);

    localparam int NB = DIV_W / 8;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        phase_e           phase;
        target_e          tgt;
        logic [CW-1:0]    cnt;
        logic [DIV_W-1:0] asm_buf;
        logic [7:0]       hold;
        logic             stall;
        logic [DIV_W-1:0] div;
        logic [7:0]       lcr;
        logic [7:0]       mcr;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic [DIV_W-1:0] merged;
    logic is_wr, is_rd, len_one;

    always_comb begin
        st_d    = st_q;
        st_d.stall = 1'b0;
        merged  = st_q.asm_buf;
        merged[{st_q.cnt, 3'b000} +: 8] = wr_data;
        is_wr   = (setup_type == REQ_TYPE_WR);
        is_rd   = (setup_type == REQ_TYPE_RD);
        len_one = (setup_len == LEN_W'(1));
        unique case (st_q.phase)
            ST_IDLE: begin
                if (setup_valid) begin
                    st_d.cnt = '0;
                    if (is_wr && setup_code == CODE_DIV_WR && setup_len == LEN_W'(NB)) begin
                        st_d.phase = ST_WDATA;
                        st_d.tgt   = TG_DIV;
                    end else if (is_wr && setup_code == CODE_LINE_WR && len_one) begin
                        st_d.phase = ST_WDATA;
                        st_d.tgt   = TG_LINE;
                    end else if (is_wr && setup_code == CODE_MDM_WR && len_one) begin
                        st_d.phase = ST_WDATA;
                        st_d.tgt   = TG_MDM;
                    end else if (is_rd && setup_code == CODE_LINE_RD && len_one) begin
                        st_d.phase = ST_RDATA;
                        st_d.hold  = st_q.lcr;
                    end else if (is_rd && setup_code == CODE_STAT_RD && len_one) begin
                        st_d.phase = ST_RDATA;
                        st_d.hold  = msr_in;
                    end else begin
                        st_d.stall = 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                if (wr_valid) begin
                    unique case (st_q.tgt)
                        TG_DIV: begin
                            st_d.asm_buf = merged;
                            if (st_q.cnt == CW'(NB - 1)) begin
                                st_d.div   = merged;
                                st_d.phase = ST_IDLE;
                            end else begin
                                st_d.cnt = st_q.cnt + 1'b1;
                            end
                        end
                        TG_LINE: begin
                            st_d.lcr   = wr_data;
                            st_d.phase = ST_IDLE;
                        end
                        default: begin
                            st_d.mcr   = wr_data;
                            st_d.phase = ST_IDLE;
                        end
                    endcase
                end
            end
            default: begin
                if (rd_ready) st_d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= ST_IDLE;
            st_q.tgt   <= TG_DIV;
            st_q.mcr   <= MCR_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ready = (st_q.phase == ST_WDATA);
    assign rd_valid = (st_q.phase == ST_RDATA);
    assign rd_data  = st_q.hold;
    assign stall    = st_q.stall;
    assign divisor  = st_q.div;
    assign lcr      = st_q.lcr;
    assign mcr      = st_q.mcr;

endmodule

// File: rtl/vreq_report.sv
module vreq_report #(
    parameter logic [7:0] MSR_WATCH = 8'h0F,
    parameter logic [7:0] LSR_WATCH = 8'h9E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] msr_in,
    input  logic [7:0] lsr_in,
    output logic       rpt_valid,
    output logic [7:0] rpt_data,
    output logic       rpt_last,
    input  logic       rpt_ready
);

    typedef struct packed {
        logic [7:0] seen_m;
        logic [7:0] seen_l;
        logic [7:0] msr;
        logic [7:0] lsr;
        logic       pend;
        logic       second;
    } rpt_s;

    rpt_s rs_d, rs_q;
    logic moved;

    always_comb begin
        rs_d        = rs_q;
        rs_d.seen_m = msr_in & MSR_WATCH;
        rs_d.seen_l = lsr_in & LSR_WATCH;
        moved = ((msr_in & MSR_WATCH) != rs_q.seen_m) ||
                ((lsr_in & LSR_WATCH) != rs_q.seen_l);
        if (moved) begin
            rs_d.pend   = 1'b1;
            rs_d.second = 1'b0;
            rs_d.msr    = msr_in;
            rs_d.lsr    = lsr_in;
        end else if (rs_q.pend && rpt_ready) begin
            if (!rs_q.second) begin
                rs_d.second = 1'b1;
            end else begin
                rs_d.pend   = 1'b0;
                rs_d.second = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rpt_valid = rs_q.pend;
    assign rpt_data  = rs_q.second ? rs_q.lsr : rs_q.msr;
    assign rpt_last  = rs_q.pend && rs_q.second;

endmodule

// File: rtl/vreq_uart_bridge.sv
module vreq_uart_bridge #(
    parameter int DIV_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic [7:0]       setup_type,
    input  logic [7:0]       setup_code,
    input  logic [LEN_W-1:0] setup_len,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    input  logic             rd_ready,
    input  logic [7:0]       msr_in,
    input  logic [7:0]       lsr_in,
    output logic             stall,
    output logic [DIV_W-1:0] divisor,
    output logic [7:0]       lcr,
    output logic [7:0]       mcr,
    output logic             rpt_valid,
    output logic [7:0]       rpt_data,
    output logic             rpt_last,
    input  logic             rpt_ready
);

    vreq_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W), .MCR_INIT(8'h08)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_type(setup_type),
        .setup_code(setup_code), .setup_len(setup_len),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .msr_in(msr_in), .stall(stall),
        .divisor(divisor), .lcr(lcr), .mcr(mcr)
    );

    vreq_report #(.MSR_WATCH(8'h0F), .LSR_WATCH(8'h9E)) u_report (
        .clk(clk), .rst_n(rst_n),
        .msr_in(msr_in), .lsr_in(lsr_in),
        .rpt_valid(rpt_valid), .rpt_data(rpt_data),
        .rpt_last(rpt_last), .rpt_ready(rpt_ready)
    );

endmodule

// File: rtl/vreq_bridge_chk.sv
module vreq_bridge_chk #(
    parameter int DIV_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic             rd_ready,
    input logic             stall,
    input logic [DIV_W-1:0] divisor,
    input logic [7:0]       lcr,
    input logic [7:0]       mcr,
    input logic             rpt_valid,
    input logic             rpt_ready,
    input logic             rpt_last
);

    // R7: a rejected request leaves every register as it was
    a_r7_stall_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ($stable(divisor) && $stable(lcr) && $stable(mcr)));

    // R7: a rejected request opens no data phase
    a_r7_stall_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!wr_ready && !rd_valid));

    // R2: the divisor moves only right after an accepted write byte
    a_r2_div_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_valid && wr_ready) |-> $stable(divisor));

    // R11: read byte is held until taken
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R11: write and read phases never overlap
    a_r11_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready && rd_valid));

    // R8: taking the first report byte always leaves a byte on offer
    a_r8_second_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_ready && !rpt_last) |=> rpt_valid);

endmodule

bind vreq_uart_bridge vreq_bridge_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .stall(stall), .divisor(divisor), .lcr(lcr), .mcr(mcr),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_last(rpt_last)
);

// File: tb/vreq_uart_bridge_bench.sv
`timescale 1ns/1ps
module vreq_uart_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [7:0]  setup_type = '0;
    logic [7:0]  setup_code = '0;
    logic [15:0] setup_len = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        rd_ready = 1'b0;
    logic [7:0]  msr_in = '0;
    logic [7:0]  lsr_in = '0;
    logic        stall;
    logic [31:0] divisor;
    logic [7:0]  lcr;
    logic [7:0]  mcr;
    logic        rpt_valid;
    logic [7:0]  rpt_data;
    logic        rpt_last;
    logic        rpt_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vreq_uart_bridge u_vreq_uart_bridge (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_type(setup_type),
        .setup_code(setup_code), .setup_len(setup_len),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .msr_in(msr_in), .lsr_in(lsr_in), .stall(stall),
        .divisor(divisor), .lcr(lcr), .mcr(mcr),
        .rpt_valid(rpt_valid), .rpt_data(rpt_data),
        .rpt_last(rpt_last), .rpt_ready(rpt_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_setup(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l);
        @(negedge clk);
        setup_valid = 1'b1; setup_type = t; setup_code = c; setup_len = l;
        @(negedge clk);
        setup_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic take_read(input string tag, input logic [7:0] exp);
        check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({tag, " rd_data"}, 32'(rd_data), 32'(exp));
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        check({tag, " rd_valid cleared"}, 32'(rd_valid), 32'd0);
    endtask

    task automatic take_report(input string tag, input logic [7:0] m, input logic [7:0] l);
        check({tag, " byte0 valid"}, 32'(rpt_valid), 32'd1);
        check({tag, " byte0 msr"}, 32'(rpt_data), 32'(m));
        check({tag, " byte0 last"}, 32'(rpt_last), 32'd0);
        rpt_ready = 1'b1;
        @(negedge clk);
        check({tag, " byte1 lsr"}, 32'(rpt_data), 32'(l));
        check({tag, " byte1 last"}, 32'(rpt_last), 32'd1);
        @(negedge clk);
        rpt_ready = 1'b0;
        check({tag, " drained"}, 32'(rpt_valid), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 divisor", divisor, 32'd0);
        check("R1 lcr", 32'(lcr), 32'h00);
        check("R1 mcr", 32'(mcr), 32'h08);
        check("R1 stall", 32'(stall), 32'd0);
        check("R1 wr_ready", 32'(wr_ready), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 rpt_valid", 32'(rpt_valid), 32'd0);
    endtask

    task automatic t_divisor();
        do_setup(8'h40, 8'd5, 16'd4);
        check("R11 wr_ready in phase", 32'(wr_ready), 32'd1);
        send_byte(8'h78);
        send_byte(8'h56);
        send_byte(8'h34);
        check("R2 divisor held before last byte", divisor, 32'd0);
        check("R11 wr_ready before last", 32'(wr_ready), 32'd1);
        send_byte(8'h12);
        check("R2 divisor lsb first", divisor, 32'h1234_5678);
        check("R11 wr_ready after phase", 32'(wr_ready), 32'd0);
        do_setup(8'h40, 8'd5, 16'd4);
        send_byte(8'(115200 / 9600));
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h00);
        check("R2 divisor 9600 baud", divisor, 32'd12);
    endtask

    task automatic t_line();
        do_setup(8'h40, 8'd7, 16'd1);
        send_byte(8'h1B);
        check("R3 lcr write", 32'(lcr), 32'h1B);
        check("R3 divisor untouched", divisor, 32'd12);
    endtask

    task automatic t_modem();
        do_setup(8'h40, 8'd10, 16'd1);
        send_byte(8'h0A);
        check("R4 mcr rts", 32'(mcr), 32'h0A);
        do_setup(8'h40, 8'd10, 16'd1);
        send_byte(8'h09);
        check("R4 mcr dtr", 32'(mcr), 32'h09);
        do_setup(8'h40, 8'd10, 16'd1);
        send_byte(8'h08);
        check("R4 mcr none", 32'(mcr), 32'h08);
    endtask

    task automatic t_read_line();
        do_setup(8'hC0, 8'd6, 16'd1);
        for (int i = 0; i < 3; i++) begin
            check("R11 rd held", 32'(rd_valid), 32'd1);
            @(negedge clk);
        end
        take_read("R5 lcr read", 8'h1B);
    endtask

    task automatic t_read_status();
        msr_in = 8'hB0;
        @(negedge clk);
        do_setup(8'hC0, 8'd2, 16'd1);
        msr_in = 8'h30;
        @(negedge clk);
        take_read("R6 msr read sampled", 8'hB0);
        check("R9 upper msr bits no report", 32'(rpt_valid), 32'd0);
    endtask

    task automatic t_reject(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l, input string tag);
        do_setup(t, c, l);
        check({tag, " stall high"}, 32'(stall), 32'd1);
        check({tag, " no write phase"}, 32'(wr_ready), 32'd0);
        check({tag, " no read phase"}, 32'(rd_valid), 32'd0);
        @(negedge clk);
        check({tag, " stall one cycle"}, 32'(stall), 32'd0);
        check({tag, " divisor kept"}, divisor, 32'd12);
        check({tag, " lcr kept"}, 32'(lcr), 32'h1B);
        check({tag, " mcr kept"}, 32'(mcr), 32'h08);
    endtask

    task automatic t_report();
        msr_in = 8'h31;
        @(negedge clk);
        take_report("R8 msr delta", 8'h31, 8'h00);
        lsr_in = 8'h61;
        @(negedge clk);
        @(negedge clk);
        check("R9 lsr 6,5,0 no report", 32'(rpt_valid), 32'd0);
    endtask

    task automatic t_overwrite();
        lsr_in = 8'h63;
        @(negedge clk);
        check("R8 lsr error queued", 32'(rpt_data), 32'h31);
        msr_in = 8'h33;
        @(negedge clk);
        check("R10 overwrite newest msr", 32'(rpt_data), 32'h33);
        check("R10 overwrite still first", 32'(rpt_last), 32'd0);
        rpt_ready = 1'b1;
        lsr_in = 8'h61;
        @(negedge clk);
        rpt_ready = 1'b0;
        check("R10 restart after clash", 32'(rpt_last), 32'd0);
        take_report("R10 newest report", 8'h33, 8'h61);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divisor();
        t_line();
        t_modem();
        t_read_line();
        t_read_status();
        t_reject(8'h40, 8'd3, 16'd1, "R7 unknown code");
        t_reject(8'h40, 8'd5, 16'd2, "R7 bad length");
        t_reject(8'hC0, 8'd7, 16'd1, "R7 wrong direction");
        t_report();
        t_overwrite();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule